// File: doc/BRIEF.md
# Ultra DMA Data-In Device Sequencer

This block is the device-side engine that opens an Ultra DMA read burst on a 16-bit parallel disk-style bus and then streams words to the host. When software-side logic asks for a transfer of a given number of words and the internal word FIFO holds data, the sequencer raises its transfer request. It then waits for the host's acknowledge, drives the strobe line after a settle delay, and enables its data drivers only once the host has acknowledged, released the stop line and signalled ready. After that it produces the strobe edges that carry each word.

All protocol delays are counted in clock cycles and set by parameters. The first strobe fall has both a floor (the first word must have been on the bus long enough) and a ceiling (measured from the host's ready condition). Later words go out one per strobe transition, both edges used, while the FIFO has data. A stop request or an acknowledge loss from the host during streaming ends the burst early; otherwise the burst ends when the word count is used up. In both cases the request drops and the strobe and data drivers stay on until the host releases acknowledge.

Top module: `udma_rd_seq`

## Requirements
- R1: After reset and whenever idle, `req_o`, `strb_oe_o`, `dq_oe_o` and `fifo_pop_o` are low.
- R2: A one-cycle `start_i` with `len_i` nonzero while the FIFO is not empty raises `req_o` on that clock edge; a start with `len_i` equal to zero or with an empty FIFO is ignored and `req_o` stays low.
- R3: `strb_oe_o` rises, with `strb_o` high, on the (T_ZIORDY+1)-th clock edge after the edge that first samples `ack_n_i` low (active low acknowledge).
- R4: The host ready condition is `ack_n_i` low, `halt_i` low and `rdy_n_i` low. `dq_oe_o` stays low until it is sampled, then rises on the (T_ZAD+1)-th edge after the sampling edge, carrying the first FIFO word on `dq_o`.
- R5: The first `strb_o` fall happens on the (T_ZAD+T_DVS+2)-th edge after the ready sampling edge, so the first word is held at least T_DVS cycles, the fall is no later than T_FS cycles after ready, and `req_o` stays high until that fall.
- R6: Each later word is placed on `dq_o` one cycle before a single `strb_o` transition that carries it; every transition carries exactly one word, in FIFO order, and while the FIFO is empty `strb_o` does not change.
- R7: After the last of `len_i` words has been carried, `req_o` falls on the next edge; `strb_oe_o` and `dq_oe_o` stay high until `ack_n_i` is sampled high, and fall on that edge.
- R8: During streaming, `halt_i` high or `ack_n_i` high stops all further strobe transitions on the next edge and drops `req_o` on that edge.
- R9: `fifo_pop_o` pulses once per word placed on the bus, exactly `len_i` pulses in a completed burst, and never when the remaining count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a burst |
| len_i | input | CW | Number of words in the burst |
| fifo_data_i | input | DW | Head word of the show-ahead FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Removes the head word from the FIFO |
| req_o | output | 1 | Transfer request to the host, active high |
| ack_n_i | input | 1 | Host acknowledge, active low |
| halt_i | input | 1 | Host stop request, active high |
| rdy_n_i | input | 1 | Host ready to receive, active low |
| strb_o | output | 1 | Data strobe driven by the device |
| strb_oe_o | output | 1 | Output enable for the strobe line |
| dq_o | output | DW | Data word driven by the device |
| dq_oe_o | output | 1 | Output enable for the data bus |

## Verification
A wrong state in the start handshake appears at the ports as an enable or strobe edge that lands on the wrong clock edge, so the bench times every rise of `strb_oe_o` and `dq_oe_o` and the first strobe fall to the exact edge counted from the host stimulus. A wrong word count or a skipped wait shows up within one word time as an extra, missing or out-of-order word under the strobe, which the scoreboard catches at the transition itself. Abort and completion errors show within a cycle or two as a request that stays high, a strobe that keeps toggling, or drivers that release before the host drops acknowledge.

// File: rtl/udma_pkg.sv
package udma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PREP,
    ST_ZAD,
    ST_DVS,
    ST_XFER,
    ST_DRAIN
  } seq_state_t;
endpackage

// File: rtl/udma_dly_cnt.sv
module udma_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R5: the delay timers never move backwards while running
  assert_count_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/udma_word_ctr.sv
module udma_word_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) left <= '0;
    else if (load) left <= load_val;
    else if (dec) left <= left - 1'b1;
  end

  assign zero = (left == '0);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
endmodule

// File: rtl/udma_rd_seq.sv
module udma_rd_seq
  import udma_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int T_ZIORDY = 2,
  parameter int T_ZAD    = 2,
  parameter int T_DVS    = 3,
  parameter int T_FS     = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  input  logic [DW-1:0] fifo_data_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  output logic          req_o,
  input  logic          ack_n_i,
  input  logic          halt_i,
  input  logic          rdy_n_i,
  output logic          strb_o,
  output logic          strb_oe_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  localparam int TMR_W   = $clog2(T_FS + 2) + 1;
  localparam int FALL_AT = T_ZAD + T_DVS + 1;
  localparam logic [TMR_W-1:0] ZIO_C  = TMR_W'(T_ZIORDY);
  localparam logic [TMR_W-1:0] ZAD_C  = TMR_W'(T_ZAD);
  localparam logic [TMR_W-1:0] FALL_C = TMR_W'(FALL_AT);
  localparam logic [TMR_W-1:0] TFS_C  = TMR_W'(T_FS);

  initial begin
    assert (T_ZIORDY >= 1 && T_ZIORDY <= T_ZAD + T_DVS + 1)
      else $error("T_ZIORDY out of range");
    assert (T_FS >= T_ZAD + T_DVS + 2)
      else $error("T_FS too small for T_ZAD and T_DVS");
  end

  seq_state_t       state;
  logic [TMR_W-1:0] zcnt, rcnt;
  logic             zclr, rclr;
  logic             host_ready, abort, load_word, accept;
  logic             left_zero, armed, first_fell;

  assign zclr = (state == ST_IDLE) || (state == ST_REQ);
  assign rclr = zclr || (state == ST_PREP);

  udma_dly_cnt #(.W(TMR_W)) u_zio_tmr (
    .clk(clk), .rst(rst), .clr(zclr), .cnt(zcnt)
  );

  udma_dly_cnt #(.W(TMR_W)) u_rdy_tmr (
    .clk(clk), .rst(rst), .clr(rclr), .cnt(rcnt)
  );

  udma_word_ctr #(.W(CW)) u_left (
    .clk(clk), .rst(rst), .load(accept), .load_val(len_i),
    .dec(load_word), .zero(left_zero)
  );

  always_comb begin
    host_ready = !ack_n_i && !halt_i && !rdy_n_i;
    accept     = (state == ST_IDLE) && start_i && (len_i != '0) && !fifo_empty_i;
    abort      = (state == ST_XFER) && (halt_i || ack_n_i);
    load_word  = ((state == ST_ZAD) && (rcnt >= ZAD_C)) ||
                 ((state == ST_XFER) && !abort && !armed && !left_zero && !fifo_empty_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_o      <= 1'b0;
      strb_o     <= 1'b0;
      strb_oe_o  <= 1'b0;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
      fifo_pop_o <= 1'b0;
      armed      <= 1'b0;
      first_fell <= 1'b0;
    end else begin
      fifo_pop_o <= load_word;
      if (load_word) dq_o <= fifo_data_i;

      if ((state == ST_PREP || state == ST_ZAD || state == ST_DVS) &&
          !strb_oe_o && (zcnt >= ZIO_C)) begin
        strb_oe_o <= 1'b1;
        strb_o    <= 1'b1;
      end

      case (state)
        ST_IDLE: begin
          first_fell <= 1'b0;
          if (accept) begin
            req_o <= 1'b1;
            state <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (!ack_n_i) state <= ST_PREP;
        end
        ST_PREP: begin
          if (host_ready) state <= ST_ZAD;
        end
        ST_ZAD: begin
          if (load_word) begin
            dq_oe_o <= 1'b1;
            state   <= ST_DVS;
          end
        end
        ST_DVS: begin
          if (strb_oe_o && (rcnt >= FALL_C)) begin
            strb_o     <= 1'b0;
            first_fell <= 1'b1;
            state      <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (abort) begin
            req_o <= 1'b0;
            armed <= 1'b0;
            state <= ST_DRAIN;
          end else if (armed) begin
            strb_o <= ~strb_o;
            armed  <= 1'b0;
          end else if (left_zero) begin
            req_o <= 1'b0;
            state <= ST_DRAIN;
          end else if (load_word) begin
            armed <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (ack_n_i) begin
            strb_oe_o <= 1'b0;
            strb_o    <= 1'b0;
            dq_oe_o   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!req_o && !strb_oe_o && !dq_oe_o));

  assert_strobe_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_oe_o) |-> (zcnt > ZIO_C && strb_o));

  assert_data_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe_o) |-> (rcnt > ZAD_C));

  assert_first_fall_tfs_R5: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_XFER) && ($past(state) == ST_DVS)) |-> (rcnt <= TFS_C));

  assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> first_fell);

  assert_toggle_with_data_R6: assert property (@(posedge clk) disable iff (rst)
    (strb_oe_o && $past(strb_oe_o) && !$stable(strb_o)) |-> dq_oe_o);

  assert_quiet_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRAIN) |-> ($stable(strb_o) && !req_o));
endmodule

// File: tb/sim_udma_rd_seq.sv
module sim_udma_rd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, CW = 16;
  localparam int TZIO = 2, TZAD = 2, TDVS = 3, TFS = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_i;
  logic [CW-1:0] len_i;
  logic [DW-1:0] fifo_data_i;
  logic          fifo_empty_i;
  logic          fifo_pop_o;
  logic          req_o;
  logic          ack_n_i, halt_i, rdy_n_i;
  logic          strb_o, strb_oe_o;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  udma_rd_seq #(.DW(DW), .CW(CW), .T_ZIORDY(TZIO), .T_ZAD(TZAD),
                .T_DVS(TDVS), .T_FS(TFS)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .fifo_data_i(fifo_data_i), .fifo_empty_i(fifo_empty_i), .fifo_pop_o(fifo_pop_o),
    .req_o(req_o), .ack_n_i(ack_n_i), .halt_i(halt_i), .rdy_n_i(rdy_n_i),
    .strb_o(strb_o), .strb_oe_o(strb_oe_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0, n_fail = 0;
  int words_seen = 0, pops_seen = 0;
  logic prev_strb = 1'b0, prev_oe = 1'b0;
  logic [DW-1:0] fifo_q[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] wval = 16'h1234;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void fifo_refresh();
    fifo_empty_i = (fifo_q.size() == 0);
    fifo_data_i  = (fifo_q.size() == 0) ? '0 : fifo_q[0];
  endfunction

  task automatic push_word();
    fifo_q.push_back(wval);
    exp_q.push_back(wval);
    wval = wval + 16'h0F1B;
    fifo_refresh();
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // Monitor: FIFO model plus scoreboard of strobed words
  always @(negedge clk) begin
    logic [DW-1:0] e;
    if (fifo_pop_o) begin
      pops_seen++;
      if (fifo_q.size() > 0) void'(fifo_q.pop_front());
      fifo_refresh();
    end
    if (strb_oe_o && prev_oe && (strb_o != prev_strb)) begin
      words_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R6", "word with empty scoreboard", int'(dq_o), -1);
      else begin
        e = exp_q.pop_front();
        chk(dq_o == e, "R6", "strobed word order", int'(dq_o), int'(e));
      end
    end
    prev_strb = strb_o;
    prev_oe   = strb_oe_o;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  // mode: 0 complete, 1 stop request, 2 acknowledge loss
  task automatic run_burst(input int len, input bit stall, input int mode, input int cut);
    int base_w, base_p, c0, g, w_at;
    base_w = words_seen;
    base_p = pops_seen;
    for (int i = 0; i < (stall ? 1 : len); i++) push_word();
    start_i = 1'b1;
    len_i   = CW'(len);
    tick();
    start_i = 1'b0;
    chk(req_o == 1'b1, "R2", "request after start", int'(req_o), 1);
    ack_n_i = 1'b0;
    c0 = cyc;
    g = 0;
    while (!strb_oe_o && g < 100) begin tick(); g++; end
    chk(cyc - c0 == TZIO + 2, "R3", "strobe enable edge", cyc - c0, TZIO + 2);
    chk(strb_o == 1'b1, "R3", "strobe high when first driven", int'(strb_o), 1);
    chk(dq_oe_o == 1'b0, "R4", "data drivers off before ready", int'(dq_oe_o), 0);
    halt_i  = 1'b0;
    rdy_n_i = 1'b0;
    c0 = cyc;
    g = 0;
    while (!dq_oe_o && g < 100) begin tick(); g++; end
    chk(cyc - c0 == TZAD + 2, "R4", "data enable edge", cyc - c0, TZAD + 2);
    chk(exp_q.size() > 0 && dq_o == exp_q[0], "R4", "first word on bus",
        int'(dq_o), (exp_q.size() > 0) ? int'(exp_q[0]) : -1);
    g = 0;
    while (strb_o && g < 100) begin tick(); g++; end
    chk(cyc - c0 == TZAD + TDVS + 3, "R5", "first strobe fall edge", cyc - c0, TZAD + TDVS + 3);
    chk(cyc - c0 - 1 <= TFS, "R5", "first fall within ready bound", cyc - c0 - 1, TFS);
    chk(req_o == 1'b1, "R5", "request held through first fall", int'(req_o), 1);
    if (stall) begin
      repeat (6) tick();
      chk(words_seen - base_w == 1, "R6", "no strobe while FIFO empty", words_seen - base_w, 1);
      chk(req_o == 1'b1, "R6", "request held while stalled", int'(req_o), 1);
      for (int i = 1; i < len; i++) push_word();
    end
    if (mode != 0) begin
      g = 0;
      while (words_seen - base_w < cut && g < 200) begin tick(); g++; end
      if (mode == 1) halt_i = 1'b1;
      else ack_n_i = 1'b1;
      w_at = words_seen;
      repeat (8) tick();
      chk(words_seen == w_at, "R8", "no strobe after abort", words_seen, w_at);
      chk(req_o == 1'b0, "R8", "request dropped after abort", int'(req_o), 0);
      ack_n_i = 1'b1; halt_i = 1'b1; rdy_n_i = 1'b1;
      tick(); tick();
      chk(!strb_oe_o && !dq_oe_o, "R8", "drivers released after abort",
          int'(strb_oe_o) + int'(dq_oe_o), 0);
      fifo_q.delete();
      exp_q.delete();
      fifo_refresh();
    end else begin
      g = 0;
      while (words_seen - base_w < len && g < 400) begin tick(); g++; end
      chk(req_o == 1'b1, "R7", "request still high at last word", int'(req_o), 1);
      tick();
      chk(req_o == 1'b0, "R7", "request drop after last word", int'(req_o), 0);
      chk(words_seen - base_w == len, "R7", "word count", words_seen - base_w, len);
      chk(pops_seen - base_p == len, "R9", "pop count", pops_seen - base_p, len);
      tick();
      chk(strb_oe_o && dq_oe_o, "R7", "drivers held until ack release",
          int'(strb_oe_o) + int'(dq_oe_o), 2);
      chk(words_seen - base_w == len, "R9", "no extra word", words_seen - base_w, len);
      ack_n_i = 1'b1; halt_i = 1'b1; rdy_n_i = 1'b1;
      tick();
      chk(!strb_oe_o && !dq_oe_o, "R7", "drivers off after ack release",
          int'(strb_oe_o) + int'(dq_oe_o), 0);
    end
    tick();
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; len_i = '0;
    ack_n_i = 1'b1; halt_i = 1'b1; rdy_n_i = 1'b1;
    fifo_refresh();
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk(!req_o && !strb_oe_o && !dq_oe_o && !fifo_pop_o, "R1", "idle outputs after reset",
        int'(req_o) + int'(strb_oe_o) + int'(dq_oe_o) + int'(fifo_pop_o), 0);

    // R2: zero length ignored even with data present
    fifo_q.push_back(16'hBEEF);
    fifo_refresh();
    start_i = 1'b1; len_i = '0;
    tick();
    start_i = 1'b0;
    repeat (3) tick();
    chk(req_o == 1'b0, "R2", "zero length start ignored", int'(req_o), 0);
    fifo_q.delete();
    fifo_refresh();
    // R2: empty FIFO start ignored
    start_i = 1'b1; len_i = CW'(4);
    tick();
    start_i = 1'b0;
    repeat (3) tick();
    chk(req_o == 1'b0, "R2", "empty FIFO start ignored", int'(req_o), 0);
    chk(fifo_pop_o == 1'b0, "R1", "no pop while idle", int'(fifo_pop_o), 0);

    run_burst(1, 1'b0, 0, 0);
    run_burst(5, 1'b0, 0, 0);
    run_burst(4, 1'b1, 0, 0);
    run_burst(8, 1'b0, 1, 3);
    run_burst(6, 1'b0, 2, 2);
    run_burst(3, 1'b0, 0, 0);

    summary();
    $finish;
  end
endmodule